// File: doc/BRIEF.md
# Programmable Serial Frame Timing Sequencer

This block is a master-side serial engine. For each word it generates the bit clock, the frame sync and the serial data, and it captures a received word. A transfer is accepted through a valid/ready handshake. The block then walks through four phases in a fixed order: a start delay with the clock parked low, a number of dummy clocks, the data bits sent most significant first, and a number of trailing dummy clocks.

The frame sync is placed independently of the data. Its leading edge is set in half-clock steps, counted from the end of the start delay, and it stays high for a programmable number of clock periods. All timing fields come from a 32-bit control word, and the data size comes from a separate input. Both are sampled when a word is accepted, so a write during a transfer does not disturb it.

The serial clock is the system clock divided by an even ratio `DIV` of at least 4. Every half period therefore lasts `DIV/2` system cycles, and half-period frame steps fall on system clock edges. A combinational error flag reports control values that break the legal limits.

Top module: `pfs_seq`

## Requirements
- R1: While reset is held and right after it is released, `tx_ready` is 1 and `sclk`, `frame`, `txd` and `rx_valid` are 0.
- R2: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` stays 0 from the next cycle until the transfer and its rest period are over. With L = S+DS+N+DE serial periods, `tx_ready` returns in system cycle (2L+2)·DIV/2+1 after the accepting edge.
- R3: The transfer has 2L half periods of DIV/2 system cycles each. `sclk` is 0 for the first 2S halves. After that, each serial period is one low half followed by one high half.
- R4: `txd` carries the low N bits of the accepted word, most significant first, one bit per serial period in the N periods that follow the S+DS delay and dummy periods. Bits change at the start of a period (falling `sclk`). `txd` is 0 in every other period.
- R5: `rxd` is sampled on the rising `sclk` of each data period. In the cycle after the last sample, `rx_valid` is 1 for exactly one cycle, and `rx_data` holds the N received bits right-aligned with zeros above them.
- R6: `frame` is 1 in half periods 2S+FD up to, but not including, 2S+FD+2·FW, counted from the start of the transfer. It is cut off where the transfer ends.
- R7: After every transfer the block spends one full serial period in a rest state with `sclk`, `frame` and `txd` at 0 before it accepts another word. `frame` is therefore low for at least DIV system cycles before each new transfer.
- R8: The control word fields are: start delay S in bits 6:4, dummy-start DS in bits 8:7, frame delay FD (in half periods) in bits 15:9, frame width FW (in periods) in bits 22:16, and dummy-stop DE in bits 24:23. Bits 31:25 and 3:0 have no effect.
- R9: The data size input is legal from 4 to 32. A value below 4 is used as 4 and a value above 32 is used as 32.
- R10: `cfg_err` is 1, combinationally on the current inputs, exactly when FW > 45, FD > 74, or the data size is outside 4..32.
- R11: A change to `ctrl`, `data_bits` or `tx_data` after a word is accepted does not change that transfer. The new values apply only from the next accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 32 | Timing control word |
| data_bits | input | NB_W (6) | Data size in bits |
| tx_data | input | DMAX (32) | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Sequencer idle, word can be accepted |
| rxd | input | 1 | Serial receive data |
| sclk | output | 1 | Serial bit clock |
| frame | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |
| rx_data | output | DMAX (32) | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| cfg_err | output | 1 | Illegal control or size value |

## Verification
The bench sweeps start delay, both dummy counts and three data sizes. Frame delays and widths are spread across their range, and every cycle of every transfer is compared against an arithmetic model. The following cases are targeted:

- A frame that runs past the end of the transfer. A sequencer that did not cut it off would still drive `frame` during the rest period.
- A frame delay of 74, which can never be reached in a short transfer.
- Limit values on both sides of each bound (width 45/46, delay 74/75, size 3/4/32/33). An off-by-one comparator flips `cfg_err` on one of these.
- Data sizes out of range, which must shift the word by the clamped count.
- A control word rewritten in the middle of a transfer. A sequencer that read live fields instead of latched ones would move the clock or the frame partway through.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

   // control word field widths
   localparam int SDLY_W = 3;
   localparam int DSTA_W = 2;
   localparam int FDLY_W = 7;
   localparam int FWID_W = 7;
   localparam int DSTO_W = 2;

   // highest legal frame delay in half periods
   localparam int FDLY_LIMIT = 74;

   typedef struct packed {
      logic [DSTO_W-1:0] dstop;
      logic [FWID_W-1:0] fwid;
      logic [FDLY_W-1:0] fdly;
      logic [DSTA_W-1:0] dstart;
      logic [SDLY_W-1:0] sdly;
   } pfs_fields_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_REST
   } pfs_state_t;

   // takes control word bits 24:4
   function automatic pfs_fields_t pfs_decode(input logic [20:0] w);
      pfs_fields_t f;
      f.sdly   = w[2:0];
      f.dstart = w[4:3];
      f.fdly   = w[11:5];
      f.fwid   = w[18:12];
      f.dstop  = w[20:19];
      return f;
   endfunction

endpackage

// File: rtl/pfs_cfg.sv
module pfs_cfg
   import pfs_pkg::*;
#(
   parameter int DMAX = 32,
   parameter int HW   = 9,
   parameter int NB_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     ctrl,
   input  logic [NB_W-1:0] data_bits,
   input  logic            start,
   output logic            cfg_err,
   output logic [NB_W-1:0] n_now,
   output logic [HW-1:0]   h_act,
   output logic [HW-1:0]   h_dat,
   output logic [HW-1:0]   h_dend,
   output logic [HW-1:0]   h_end,
   output logic [HW-1:0]   h_fon,
   output logic [HW-1:0]   h_foff
);

   localparam int FWID_LIM = (2**SDLY_W - 1) + (2**DSTA_W - 1) + DMAX + (2**DSTO_W - 1);

   pfs_fields_t f;
   logic        size_lo, size_hi;
   logic [HW-1:0] act_n, dat_n, dend_n, end_n, fon_n, foff_n;

   wire unused_rsvd = ^{ctrl[31:25], ctrl[3:0]};

   assign f = pfs_decode(ctrl[24:4]);

   always_comb begin
      size_lo = data_bits < NB_W'(4);
      size_hi = data_bits > NB_W'(DMAX);
      n_now   = size_lo ? NB_W'(4) : (size_hi ? NB_W'(DMAX) : data_bits);
      cfg_err = (HW'(f.fwid) > HW'(FWID_LIM)) ||
                (HW'(f.fdly) > HW'(FDLY_LIMIT)) ||
                size_lo || size_hi;
   end

   // phase boundaries, all in half periods from the start of the transfer
   always_comb begin
      act_n  = HW'({f.sdly, 1'b0});
      dat_n  = act_n  + HW'({f.dstart, 1'b0});
      dend_n = dat_n  + HW'({n_now, 1'b0});
      end_n  = dend_n + HW'({f.dstop, 1'b0});
      fon_n  = act_n  + HW'(f.fdly);
      foff_n = fon_n  + HW'({f.fwid, 1'b0});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_act  <= '0;
         h_dat  <= '0;
         h_dend <= '0;
         h_end  <= '0;
         h_fon  <= '0;
         h_foff <= '0;
      end else if (start) begin
         h_act  <= act_n;
         h_dat  <= dat_n;
         h_dend <= dend_n;
         h_end  <= end_n;
         h_fon  <= fon_n;
         h_foff <= foff_n;
      end
   end

endmodule

// File: rtl/pfs_timer.sv
module pfs_timer
   import pfs_pkg::*;
#(
   parameter int DIV = 4,
   parameter int HW  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [HW-1:0] h_end,
   output logic          ready,
   output logic          run,
   output logic [HW-1:0] h,
   output logic          rise_edge,
   output logic          per_end
);

   localparam int HALF = DIV / 2;
   localparam int SW   = (HALF > 1) ? $clog2(HALF) : 1;

   pfs_state_t    st;
   logic [SW-1:0] sub;
   logic          sub_last;
   logic          adv;

   assign sub_last  = (sub == SW'(HALF - 1));
   assign adv       = (st != ST_IDLE) && sub_last;
   assign ready     = (st == ST_IDLE);
   assign run       = (st == ST_RUN);
   assign rise_edge = adv && run && !h[0];
   assign per_end   = adv && run && h[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         sub <= '0;
         h   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st  <= ST_RUN;
                  sub <= '0;
                  h   <= '0;
               end
            end
            ST_RUN: begin
               if (sub_last) begin
                  sub <= '0;
                  if (h == h_end - 1'b1) begin
                     st <= ST_REST;
                     h  <= '0;
                  end else begin
                     h <= h + 1'b1;
                  end
               end else begin
                  sub <= sub + 1'b1;
               end
            end
            default: begin
               if (sub_last) begin
                  sub <= '0;
                  if (h == HW'(1)) begin
                     st <= ST_IDLE;
                     h  <= '0;
                  end else begin
                     h <= h + 1'b1;
                  end
               end else begin
                  sub <= sub + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pfs_shift.sv
module pfs_shift #(
   parameter int DMAX = 32,
   parameter int HW   = 9,
   parameter int NB_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [DMAX-1:0] tx_data,
   input  logic [NB_W-1:0] n_now,
   input  logic            run,
   input  logic [HW-1:0]   h,
   input  logic [HW-1:0]   h_dat,
   input  logic [HW-1:0]   h_dend,
   input  logic            rise_edge,
   input  logic            per_end,
   input  logic            rxd,
   output logic            txd,
   output logic [DMAX-1:0] rx_data,
   output logic            rx_valid
);

   logic [DMAX-1:0] tx_sr;
   logic            in_data;
   logic [NB_W-1:0] pad;

   assign in_data = run && (h >= h_dat) && (h < h_dend);
   assign pad     = NB_W'(DMAX) - n_now;
   assign txd     = in_data && tx_sr[DMAX-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (start) begin
            tx_sr   <= tx_data << pad;
            rx_data <= '0;
         end else begin
            if (per_end && in_data) begin
               tx_sr <= {tx_sr[DMAX-2:0], 1'b0};
            end
            if (rise_edge && in_data) begin
               rx_data  <= {rx_data[DMAX-2:0], rxd};
               rx_valid <= (h == h_dend - HW'(2));
            end
         end
      end
   end

endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
   import pfs_pkg::*;
#(
   parameter int DIV  = 4,
   parameter int DMAX = 32,
   localparam int NB_W = $clog2(DMAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     ctrl,
   input  logic [NB_W-1:0] data_bits,
   input  logic [DMAX-1:0] tx_data,
   input  logic            tx_valid,
   output logic            tx_ready,
   input  logic            rxd,
   output logic            sclk,
   output logic            frame,
   output logic            txd,
   output logic [DMAX-1:0] rx_data,
   output logic            rx_valid,
   output logic            cfg_err
);

   localparam int MAX_END  = 2 * ((2**SDLY_W - 1) + (2**DSTA_W - 1) + DMAX + (2**DSTO_W - 1));
   localparam int MAX_FOFF = 2 * (2**SDLY_W - 1) + (2**FDLY_W - 1) + 2 * (2**FWID_W - 1);
   localparam int MAX_H    = (MAX_END > MAX_FOFF) ? MAX_END : MAX_FOFF;
   localparam int HW       = $clog2(MAX_H + 1);

   generate
      if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
         $error("pfs_seq: DIV must be even and at least 4");
      end
      if (DMAX < 4) begin : g_bad_dmax
         $error("pfs_seq: DMAX must be at least 4");
      end
   endgenerate

   logic          start;
   logic          run;
   logic          rise_edge, per_end;
   logic [HW-1:0] h;
   logic [HW-1:0] h_act, h_dat, h_dend, h_end, h_fon, h_foff;
   logic [NB_W-1:0] n_now;

   assign start = tx_valid && tx_ready;

   pfs_cfg #(.DMAX(DMAX), .HW(HW), .NB_W(NB_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .data_bits (data_bits),
      .start     (start),
      .cfg_err   (cfg_err),
      .n_now     (n_now),
      .h_act     (h_act),
      .h_dat     (h_dat),
      .h_dend    (h_dend),
      .h_end     (h_end),
      .h_fon     (h_fon),
      .h_foff    (h_foff)
   );

   pfs_timer #(.DIV(DIV), .HW(HW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .h_end     (h_end),
      .ready     (tx_ready),
      .run       (run),
      .h         (h),
      .rise_edge (rise_edge),
      .per_end   (per_end)
   );

   pfs_shift #(.DMAX(DMAX), .HW(HW), .NB_W(NB_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tx_data   (tx_data),
      .n_now     (n_now),
      .run       (run),
      .h         (h),
      .h_dat     (h_dat),
      .h_dend    (h_dend),
      .rise_edge (rise_edge),
      .per_end   (per_end),
      .rxd       (rxd),
      .txd       (txd),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid)
   );

   // clock idles low through the start delay; odd halves are the high halves
   assign sclk  = run && (h >= h_act) && h[0];
   assign frame = run && (h >= h_fon) && (h < h_foff);

endmodule

// File: rtl/pfs_seq_sva.sv
module pfs_seq_sva #(
   parameter int DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic sclk,
   input logic frame,
   input logic txd,
   input logic rx_valid
);

   int low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= DIV;
      else if (frame)      low_cnt <= 0;
      else if (low_cnt < DIV) low_cnt <= low_cnt + 1;
   end

   p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   p_sclk_high_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |=> sclk);

   p_sclk_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |=> !sclk);

   p_rx_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_rx_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !tx_ready);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!sclk && !frame && !txd));

   p_frame_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |-> (low_cnt >= DIV));

endmodule

bind pfs_seq pfs_seq_sva #(.DIV(DIV)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .sclk     (sclk),
   .frame    (frame),
   .txd      (txd),
   .rx_valid (rx_valid)
);

// File: tb/pfs_seq_test.sv
module pfs_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int HALF       = DIV / 2;
   localparam int DMAX       = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl;
   logic [5:0]  data_bits;
   logic [31:0] tx_data;
   logic        tx_valid;
   logic        rxd;
   logic        tx_ready, sclk, frame, txd, rx_valid, cfg_err;
   logic [31:0] rx_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfs_seq #(.DIV(DIV), .DMAX(DMAX)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .data_bits (data_bits),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .rxd       (rxd),
      .sclk      (sclk),
      .frame     (frame),
      .txd       (txd),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .cfg_err   (cfg_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // R8 field layout
   function automatic logic [31:0] mk(input int s, input int ds, input int fd,
                                      input int fw, input int de);
      logic [31:0] w;
      w = '0;
      w[6:4]   = 3'(s);
      w[8:7]   = 2'(ds);
      w[15:9]  = 7'(fd);
      w[22:16] = 7'(fw);
      w[24:23] = 2'(de);
      return w;
   endfunction

   task automatic cfg_probe(input logic [31:0] cw, input logic [5:0] nb,
                            input bit exp, input string req);
      @(negedge clk);
      ctrl = cw;
      data_bits = nb;
      #1;
      check(cfg_err === exp, req, "cfg_err", cfg_err, exp);
   endtask

   task automatic xfer(input logic [31:0] cw, input logic [5:0] nb,
                       input logic [31:0] word, input logic [31:0] rpat,
                       input bit midchg, input string ctx);
      int s, ds, fd, fw, de, n, l, run_end, last_c, h, k;
      int bad_sclk, bad_txd, bad_frm, bad_rest, bad_rdy, rxv_seen, rxv_bad;
      logic [31:0] mask, rx_got;
      logic e_sclk, e_txd, e_frm, e_rxv;
      bad_sclk = 0; bad_txd = 0; bad_frm = 0; bad_rest = 0; bad_rdy = 0;
      rxv_seen = 0; rxv_bad = 0; rx_got = '0;
      s  = int'(cw[6:4]);
      ds = int'(cw[8:7]);
      fd = int'(cw[15:9]);
      fw = int'(cw[22:16]);
      de = int'(cw[24:23]);
      n  = (nb < 4) ? 4 : ((nb > 32) ? 32 : int'(nb));   // R9 clamp
      l  = s + ds + n + de;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
      run_end = 2 * l * HALF;
      last_c  = (2 * l + 2) * HALF + 1;

      @(negedge clk);
      ctrl = cw; data_bits = nb; tx_data = word; tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      for (int c = 1; c <= last_c; c++) begin
         if (c > 1) @(negedge clk);
         h = (c - 1) / HALF;
         k = (h / 2) - s - ds;
         if (c <= run_end) begin
            e_sclk = (h >= 2 * s) && (h % 2 == 1);
            e_txd  = (k >= 0 && k < n) ? word[n - 1 - k] : 1'b0;
            e_frm  = (h >= 2 * s + fd) && (h < 2 * s + fd + 2 * fw);
            e_rxv  = (h == 2 * (s + ds + n) - 1) && ((c - 1) % HALF == 0);
            if (sclk !== e_sclk) bad_sclk++;
            if (txd !== e_txd)   bad_txd++;
            if (frame !== e_frm) bad_frm++;
            if (tx_ready !== 1'b0) bad_rdy++;
            if (rx_valid !== e_rxv) rxv_bad++;
            rxd = (k >= 0 && k < n) ? rpat[n - 1 - k] : 1'(c & 1);
         end else begin
            if (sclk !== 1'b0 || frame !== 1'b0 || txd !== 1'b0) bad_rest++;
            if (tx_ready !== (c == last_c)) bad_rdy++;
            if (rx_valid !== 1'b0) rxv_bad++;
            rxd = 1'(c & 1);
         end
         if (rx_valid === 1'b1) begin
            rxv_seen++;
            rx_got = rx_data;
         end
         if (midchg && c == 3) begin     // R11: disturb latched inputs
            ctrl = ~cw;
            data_bits = 6'd9;
            tx_data = ~word;
         end
      end
      check(bad_sclk == 0, {"R3 ", ctx}, "sclk mismatching cycles", bad_sclk, 0);
      check(bad_txd == 0,  {"R4 ", ctx}, "txd mismatching cycles", bad_txd, 0);
      check(bad_frm == 0,  {"R6 ", ctx}, "frame mismatching cycles", bad_frm, 0);
      check(bad_rest == 0, {"R7 ", ctx}, "rest period active cycles", bad_rest, 0);
      check(bad_rdy == 0,  {"R2 ", ctx}, "tx_ready mismatching cycles", bad_rdy, 0);
      check(rxv_bad == 0 && rxv_seen == 1, {"R5 ", ctx}, "rx_valid strobes", rxv_seen, 1);
      check(rx_got == (rpat & mask), {"R5 ", ctx}, "rx_data", rx_got, rpat & mask);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      ctrl = '0; data_bits = 6'd8; tx_data = '0; tx_valid = 1'b0; rxd = 1'b0;
      repeat (2) @(negedge clk);
      // R1 during reset
      check(tx_ready === 1'b1 && sclk === 1'b0 && frame === 1'b0 &&
            txd === 1'b0 && rx_valid === 1'b0, "R1", "outputs in reset",
            {tx_ready, sclk, frame, txd, rx_valid}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_ready === 1'b1 && sclk === 1'b0 && frame === 1'b0 &&
            txd === 1'b0 && rx_valid === 1'b0, "R1", "outputs after reset",
            {tx_ready, sclk, frame, txd, rx_valid}, 5'b10000);

      // R10 / R9 limit values
      cfg_probe(mk(0, 0, 0, 45, 0), 6'd8, 1'b0, "R10 width 45");
      cfg_probe(mk(0, 0, 0, 46, 0), 6'd8, 1'b1, "R10 width 46");
      cfg_probe(mk(0, 0, 74, 4, 0), 6'd8, 1'b0, "R10 delay 74");
      cfg_probe(mk(0, 0, 75, 4, 0), 6'd8, 1'b1, "R10 delay 75");
      cfg_probe(mk(7, 3, 74, 45, 3), 6'd32, 1'b0, "R10 all maximum");
      cfg_probe(mk(0, 0, 0, 4, 0), 6'd3, 1'b1, "R9 size 3");
      cfg_probe(mk(0, 0, 0, 4, 0), 6'd4, 1'b0, "R9 size 4");
      cfg_probe(mk(0, 0, 0, 4, 0), 6'd32, 1'b0, "R9 size 32");
      cfg_probe(mk(0, 0, 0, 4, 0), 6'd33, 1'b1, "R9 size 33");
      cfg_probe(mk(0, 0, 0, 4, 0) | 32'hFE00_000F, 6'd8, 1'b0, "R8 reserved bits");

      // directed transfers
      xfer(mk(0, 0, 0, 8, 0), 6'd8, 32'h0000_00A5, 32'h0000_003C, 1'b0, "basic");
      xfer(mk(2, 1, 3, 6, 1) | 32'hFE00_000F, 6'd8, 32'h0000_0096, 32'h0000_00C3, 1'b0, "R8 reserved set");
      xfer(mk(1, 2, 1, 2, 2), 6'd2, 32'hFFFF_FFF9, 32'h0000_000A, 1'b0, "R9 size below");
      xfer(mk(0, 1, 0, 20, 1), 6'd40, 32'hC3A5_5A3C, 32'h8001_7FFE, 1'b0, "R9 size above");
      xfer(mk(0, 0, 3, 40, 0), 6'd4, 32'h0000_0005, 32'h0000_0006, 1'b0, "R6 frame cut");
      xfer(mk(1, 0, 74, 5, 0), 6'd4, 32'h0000_000E, 32'h0000_0001, 1'b0, "R6 frame unreached");
      xfer(mk(3, 2, 5, 7, 3), 6'd12, 32'h0000_0B6D, 32'h0000_0492, 1'b1, "R11 change mid transfer");
      xfer(mk(0, 0, 0, 45, 0), 6'd4, 32'h0000_0009, 32'h0000_000F, 1'b0, "R7 back to back");
      xfer(mk(0, 0, 1, 1, 0), 6'd4, 32'h0000_0006, 32'h0000_0009, 1'b0, "R7 back to back");

      // sweep of phase counts and sizes
      for (int si = 0; si < 3; si++) begin
         for (int ds = 0; ds < 4; ds++) begin
            for (int de = 0; de < 4; de++) begin
               for (int ni = 0; ni < 3; ni++) begin
                  int s, n, fd, fw;
                  logic [31:0] w, r;
                  s  = (si == 2) ? 7 : si;
                  n  = (ni == 0) ? 4 : ((ni == 1) ? 7 : 32);
                  fd = (s * 13 + ds * 5 + n * 3 + de) % 75;
                  fw = (ds + de + n + s) % 46;
                  w  = 32'h9E37_79B9 * 32'(si * 48 + ds * 12 + de * 3 + ni + 1);
                  r  = {w[12:0], w[31:13]} ^ 32'h5A5A_F00F;
                  xfer(mk(s, ds, fd, fw, de), 6'(n), w, r, 1'b0, "sweep");
               end
            end
         end
      end

      summary();
   end

endmodule